// File: doc/BRIEF.md
# Multichannel Serial Audio Transmitter

This block sends up to eight PCM channels as a clock master. It divides the system clock to make a bit clock (`sclk`). It derives a word clock (`lrclk`) from the bit clock, and it drives four serial data lanes. Each lane carries one stereo pair of channels. The word clock marks the left slot when low and the right slot when high. Three alignment formats share the same clocks: the standard format with the MSB delayed by one bit, MSB-aligned and LSB-aligned. The sample width can be 16, 20 or 24 bits.

Samples are offered as one parallel frame of eight channels with a valid/ready handshake. The block pulses `frame_ready` once per frame, in the last system cycle before a left slot begins. A frame that is valid in that cycle is sent in the next left and right slots. If no frame is valid then, the frame already held is sent again. Change the format and width controls only while reset is asserted.

Top module: `i2s_multilane_tx`

## Requirements
- R1: Lane k (k = 0..3) carries channel 2k+1 in the left slot and channel 2k+2 in the right slot. Channel n (1..8) occupies `frame_data[(n-1)*24 +: 24]`.
- R2: Each sample goes out most significant bit first, one bit per bit-clock period.
- R3: With `fmt_mode` = 0, the sample MSB sits in slot position 1, which is the second bit period after the word-clock edge.
- R4: With `fmt_mode` = 1, the sample MSB sits in slot position 0, which coincides with the word-clock edge.
- R5: With `fmt_mode` = 2, the sample LSB sits in slot position 31, the last bit period of the half.
- R6: `width_sel` 0, 1 and 2 select 16, 20 and 24 bits, and code 3 selects 24 bits. The sample is the low W bits of its 24-bit field, and the field bits above W are ignored. Slot positions outside the sample are driven 0.
- R7: `lrclk` and `sdata` change only in the system cycle in which `sclk` falls.
- R8: `sclk` stays high for CLK_DIV system cycles and low for CLK_DIV system cycles. Each word-clock half lasts 32 bit clocks, with `lrclk` low for the left slot and high for the right slot.
- R9: `frame_ready` is a one-cycle pulse, given while `lrclk` is high, just before each left slot. A frame with `frame_valid` high in that cycle is sent in the next left and right slots.
- R10: If `frame_valid` is low at the `frame_ready` pulse, the previously accepted frame is sent again. After reset the held frame is all zeros.
- R11: While reset is asserted, `sclk` = 0, `lrclk` = 1, `sdata` = 0 and `frame_ready` = 0.
- R12: `fmt_mode` code 3 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_mode | input | 2 | Alignment: 0 standard, 1 MSB-aligned, 2 LSB-aligned, 3 standard |
| width_sel | input | 2 | Sample width: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| frame_valid | input | 1 | A new eight-channel frame is offered |
| frame_data | input | 192 | Eight 24-bit channel fields, channel 1 in the low bits |
| frame_ready | output | 1 | One-cycle pulse at which a frame is taken |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word clock, low for the left slot |
| sdata | output | 4 | Serial data lanes, one per channel pair |

## Verification
A frame accepted at the `frame_ready` edge starts to appear on the lanes one system cycle later. That cycle is the falling bit-clock edge that opens slot 0 of the left half. Each later slot bit changes at a falling edge and is due CLK_DIV system cycles later, at the next rising edge. The monitor samples on the falling system-clock edge after each rising `sclk`, where lane data and `lrclk` are settled. It regroups the bits into 64-slot frames from the word-clock transition into the left half. It then compares every lane against the frame that the driver queued at the matching ready pulse. The same monitor counts the system cycles of each `sclk` phase and the bit clocks in each word-clock half.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   localparam int WIDTH_MAX = 24;

   typedef enum logic [1:0] {
      FMT_STD       = 2'd0,
      FMT_MSB_ALIGN = 2'd1,
      FMT_LSB_ALIGN = 2'd2,
      FMT_STD_ALT   = 2'd3
   } fmt_e;

   function automatic logic [7:0] width_of(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8'd16;
         2'd1:    return 8'd20;
         default: return 8'd24;
      endcase
   endfunction

endpackage

// File: rtl/i2s_clk_gen.sv
module i2s_clk_gen #(
   parameter int CLK_DIV   = 4,
   parameter int SLOT_BITS = 32,
   localparam int SLOT_IDX_W = $clog2(SLOT_BITS),
   localparam int BIT_W      = SLOT_IDX_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  sclk,
   output logic                  lrclk,
   output logic                  fall_tick,
   output logic                  frame_wrap,
   output logic [SLOT_IDX_W-1:0] next_slot,
   output logic                  next_right
);

   logic             edge_now;
   logic [BIT_W-1:0] bit_cnt;
   logic [BIT_W-1:0] bit_nxt;

   generate
      if (CLK_DIV == 1) begin : g_div_none
         assign edge_now = 1'b1;
      end else begin : g_div_cnt
         localparam int CNT_W = $clog2(CLK_DIV);
         logic [CNT_W-1:0] div_cnt;
         assign edge_now = (div_cnt == CNT_W'(CLK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)        div_cnt <= '0;
            else if (edge_now) div_cnt <= '0;
            else               div_cnt <= div_cnt + CNT_W'(1);
         end
      end
   endgenerate

   assign bit_nxt    = bit_cnt + BIT_W'(1);
   assign fall_tick  = edge_now & sclk;
   assign frame_wrap = fall_tick & (&bit_cnt);
   assign next_slot  = bit_nxt[SLOT_IDX_W-1:0];
   assign next_right = bit_nxt[BIT_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk    <= 1'b0;
         lrclk   <= 1'b1;
         bit_cnt <= '1;
      end else if (edge_now) begin
         sclk <= ~sclk;
         if (sclk) begin
            bit_cnt <= bit_nxt;
            lrclk   <= bit_nxt[BIT_W-1];
         end
      end
   end

endmodule

// File: rtl/i2s_lane.sv
module i2s_lane
   import i2s_tx_pkg::*;
#(
   parameter int SAMPLE_MAX = 24,
   parameter int SLOT_BITS  = 32,
   localparam int SLOT_IDX_W = $clog2(SLOT_BITS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fall_tick,
   input  logic                  load,
   input  logic [SAMPLE_MAX-1:0] new_left,
   input  logic [SAMPLE_MAX-1:0] new_right,
   input  fmt_e                  mode,
   input  logic [7:0]            width_bits,
   input  logic [SLOT_IDX_W-1:0] next_slot,
   input  logic                  next_right,
   output logic                  sd
);

   logic [SAMPLE_MAX-1:0] hold_l, hold_r, src, shifted;
   logic [7:0]            lead, slot8, pos;
   logic                  in_win, bit_nxt;

   always_comb begin
      if (next_right) src = load ? new_right : hold_r;
      else            src = load ? new_left  : hold_l;
      case (mode)
         FMT_MSB_ALIGN: lead = 8'd0;
         FMT_LSB_ALIGN: lead = 8'(SLOT_BITS) - width_bits;
         default:       lead = 8'd1;
      endcase
      slot8   = 8'(next_slot);
      in_win  = (slot8 >= lead) && (slot8 < lead + width_bits);
      pos     = width_bits - 8'd1 - (slot8 - lead);
      shifted = src >> pos;
      bit_nxt = in_win & shifted[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         sd     <= 1'b0;
      end else begin
         if (load) begin
            hold_l <= new_left;
            hold_r <= new_right;
         end
         if (fall_tick) sd <= bit_nxt;
      end
   end

endmodule

// File: rtl/i2s_multilane_tx.sv
module i2s_multilane_tx
   import i2s_tx_pkg::*;
#(
   parameter int CLK_DIV    = 4,
   parameter int SLOT_BITS  = 32,
   parameter int SAMPLE_MAX = 24,
   parameter int NUM_LANES  = 4,
   localparam int NUM_CH     = 2 * NUM_LANES,
   localparam int SLOT_IDX_W = $clog2(SLOT_BITS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   fmt_mode,
   input  logic [1:0]                   width_sel,
   input  logic                         frame_valid,
   input  logic [NUM_CH*SAMPLE_MAX-1:0] frame_data,
   output logic                         frame_ready,
   output logic                         sclk,
   output logic                         lrclk,
   output logic [NUM_LANES-1:0]         sdata
);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if ((SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_slot_pow
         $error("SLOT_BITS must be a power of two");
      end
      if (SLOT_BITS < WIDTH_MAX + 1 || SLOT_BITS > 128) begin : g_bad_slot_len
         $error("SLOT_BITS must hold the widest sample plus the one-bit delay");
      end
      if (SAMPLE_MAX < WIDTH_MAX) begin : g_bad_sample
         $error("SAMPLE_MAX must cover the widest selectable sample");
      end
   endgenerate

   logic                  fall_tick, frame_wrap, next_right, load;
   logic [SLOT_IDX_W-1:0] next_slot;
   logic [7:0]            width_bits;
   fmt_e                  mode;

   assign mode        = fmt_e'(fmt_mode);
   assign width_bits  = width_of(width_sel);
   assign frame_ready = frame_wrap;
   assign load        = frame_wrap & frame_valid;

   i2s_clk_gen #(
      .CLK_DIV   (CLK_DIV),
      .SLOT_BITS (SLOT_BITS)
   ) u_clk_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (sclk),
      .lrclk      (lrclk),
      .fall_tick  (fall_tick),
      .frame_wrap (frame_wrap),
      .next_slot  (next_slot),
      .next_right (next_right)
   );

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         i2s_lane #(
            .SAMPLE_MAX (SAMPLE_MAX),
            .SLOT_BITS  (SLOT_BITS)
         ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .fall_tick  (fall_tick),
            .load       (load),
            .new_left   (frame_data[(2*g)*SAMPLE_MAX +: SAMPLE_MAX]),
            .new_right  (frame_data[(2*g+1)*SAMPLE_MAX +: SAMPLE_MAX]),
            .mode       (mode),
            .width_bits (width_bits),
            .next_slot  (next_slot),
            .next_right (next_right),
            .sd         (sdata[g])
         );
      end
   endgenerate

endmodule

// File: rtl/i2s_ser_checker.sv
module i2s_ser_checker #(
   parameter int NUM_LANES = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sclk,
   input logic                 lrclk,
   input logic [NUM_LANES-1:0] sdata,
   input logic                 frame_ready
);

   p_lr_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lrclk) |-> $fell(sclk));

   p_data_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata) |-> $fell(sclk));

   p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ready |=> !frame_ready);

   p_ready_in_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ready |-> (lrclk && sclk));

   p_left_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ready |=> ($fell(lrclk) && $fell(sclk)));

endmodule

bind i2s_multilane_tx i2s_ser_checker #(.NUM_LANES(NUM_LANES)) u_ser_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk        (sclk),
   .lrclk       (lrclk),
   .sdata       (sdata),
   .frame_ready (frame_ready)
);

// File: tb/test_i2s_multilane_tx.sv
`timescale 1ns/1ps
module test_i2s_multilane_tx;

   localparam int DIV    = 2;
   localparam int LANES  = 4;
   localparam int FW     = 2 * LANES * 24;
   localparam int NFR    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    fmt_mode = 2'd0;
   logic [1:0]    width_sel = 2'd0;
   logic          frame_valid = 1'b0;
   logic [FW-1:0] frame_data = '0;
   logic          frame_ready, sclk, lrclk;
   logic [LANES-1:0] sdata;

   int n_checks = 0;
   int n_fail   = 0;
   logic [FW-1:0] exp_q[$];

   always #4 clk = ~clk;

   i2s_multilane_tx #(.CLK_DIV(DIV)) i_i2s_multilane_tx (
      .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .width_sel(width_sel),
      .frame_valid(frame_valid), .frame_data(frame_data),
      .frame_ready(frame_ready), .sclk(sclk), .lrclk(lrclk), .sdata(sdata));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Expected bit at a slot position, built from the alignment rules (R3-R6, R12)
   function automatic logic slot_bit(input logic [1:0] m, input logic [1:0] ws,
                                     input logic [23:0] smp, input int slot);
      int w;
      logic [31:0] word, masked;
      w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 20 : 24;
      masked = {8'd0, smp} & ((32'd1 << w) - 32'd1);
      if (m == 2'd1)      word = masked << (32 - w);
      else if (m == 2'd2) word = masked;
      else                word = masked << (31 - w);
      return word[31 - slot];
   endfunction

   task automatic drive(input int cfg);
      logic [FW-1:0] last = '0;
      for (int f = 0; f < NFR; f++) begin
         logic idle = (f == 2) || (cfg == 0 && f == 0);
         logic [FW-1:0] d;
         for (int c = 0; c < 2 * LANES; c++) d[c*24 +: 24] = 24'($urandom);
         @(negedge clk);
         frame_valid = !idle;
         frame_data  = d;
         while (frame_ready !== 1'b1) @(negedge clk);
         if (!idle) last = d;          // R10: idle ready repeats last frame
         exp_q.push_back(last);
         @(negedge clk);
         frame_valid = 1'b0;
      end
   endtask

   task automatic monitor();
      logic prev_lr = 1'b1, prev_sclk = 1'b0, started = 1'b0, duty_bad = 1'b0;
      int bitpos = 0, lcnt = 0, rcnt = 0, run = 0, fr = 0;
      logic [63:0] cap [LANES];
      while (fr < NFR) begin
         @(negedge clk);
         run++;
         if (sclk != prev_sclk) begin
            if (started && run != DIV) duty_bad = 1'b1;
            run = 0;
         end
         if (sclk && !prev_sclk) begin
            if (prev_lr && !lrclk) begin
               started = 1'b1; bitpos = 0; lcnt = 0; rcnt = 0; duty_bad = 1'b0;
            end
            prev_lr = lrclk;
            if (started) begin
               for (int k = 0; k < LANES; k++) cap[k][bitpos] = sdata[k];
               if (lrclk) rcnt++; else lcnt++;
               bitpos++;
               if (bitpos == 64) begin
                  logic [FW-1:0] ef;
                  if (exp_q.size() == 0) begin
                     check("R9 frame expected", 64'd1, 64'd0);
                     ef = '0;
                  end else ef = exp_q.pop_front();
                  for (int k = 0; k < LANES; k++) begin
                     logic [63:0] e;
                     for (int s = 0; s < 32; s++) begin
                        e[s]      = slot_bit(fmt_mode, width_sel, ef[(2*k)*24 +: 24], s);
                        e[32 + s] = slot_bit(fmt_mode, width_sel, ef[(2*k+1)*24 +: 24], s);
                     end
                     check("R1 R2 R3 R4 R5 R6 R12 lane bits", cap[k], e);
                  end
                  check("R8 half lengths", 64'(lcnt * 100 + rcnt), 64'(32 * 100 + 32));
                  check("R8 sclk duty", 64'(duty_bad), 64'd0);
                  fr++; bitpos = 0; lcnt = 0; rcnt = 0; duty_bad = 1'b0;
               end
            end
         end
         prev_sclk = sclk;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      for (int cfg = 0; cfg < 12; cfg++) begin
         rst_n = 1'b0;
         fmt_mode  = 2'(cfg / 3);
         width_sel = 2'(cfg % 3);
         exp_q.delete();
         repeat (3) @(negedge clk);
         check("R11 reset outputs", {60'd0, sclk, lrclk, frame_ready, |sdata},
               {60'd0, 1'b0, 1'b1, 1'b0, 1'b0});
         rst_n = 1'b1;
         fork
            drive(cfg);
            monitor();
         join
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule